// File: doc/BRIEF.md
# Adapter Output Fault Supervisor

This block watches the output of a mode-switching charger adapter and decides when to shut the power loop down, when to fold back the current limit, and when to stop synchronous-rectifier gating. It takes a measured output-voltage code, the present output band and the fixed-mode state from a mode decoder, a low-load flag from the current-sense comparator, two external fault flags and a 1 µs tick. Every fault condition is qualified by a tick-based debounce counter that restarts from zero whenever its condition drops before the window expires.

Overvoltage, a debounced data-line overvoltage and a cable fault all set a sticky feedback pull-down latch. The latch is released only when the supply falls below a collapse level far under the normal operating range. Undervoltage is supervised only in the two fixed legacy high-voltage modes. A build-time parameter selects what an undervoltage fault does: one choice requests a reduced current limit, the other joins the pull-down latch. A light-load state with separate entry and exit windows, together with undervoltage, blocks the rectifier gate.

Top module: `out_prot_latch`

## Requirements
- R1: While and right after the synchronous reset, fb_pulldown, cc_reduce, sr_disable and light_load are all 0.
- R2: The overvoltage limit is picked from band (0: code 60, 1: code 84, 2: code 108, 3: code 144, with 1 LSB = 100 mV). A code strictly above the limit is an overvoltage. A code equal to the limit is not.
- R3: An overvoltage sets fb_pulldown only after it has held for OVP_DEB_US ticks. A shorter episode restarts the count.
- R4: A data-line overvoltage flag sets fb_pulldown only after it has held for DL_DEB_US ticks. A shorter episode restarts the count.
- R5: A cable fault sets fb_pulldown on the next clock edge when the code is not below the release level.
- R6: fb_pulldown stays set after its cause goes away. It clears on the edge after vout_code falls strictly below LATCH_OFF_CODE (default 20 = 2.0 V). Release takes priority over any set cause.
- R7: Undervoltage is armed only for leg_mode 1 (9 V fixed) or 2 (12 V fixed). It is entered when the code is strictly below 55 or 80 respectively for UV_DEB_US ticks. leg_mode 0 (default) and 3 (continuous) never enter it.
- R8: Undervoltage leaves on the edge after the code rises strictly above 60 (9 V) or 85 (12 V), or after the mode stops being armed.
- R9: With UV_REACT = UV_CUT_CC, undervoltage drives cc_reduce and leaves fb_pulldown alone. With UV_LATCH, it sets fb_pulldown and cc_reduce stays 0.
- R10: sr_disable is 1 whenever undervoltage or light-load mode is active, and 0 otherwise.
- R11: light_load sets after cs_low has held for LL_EN_US ticks. It clears after cs_low has stayed low for LL_DIS_US ticks. An interruption restarts the running window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| band | input | 2 | Output band: 0 ≤5.0 V, 1 ≤6.0 V, 2 ≤9.0 V, 3 ≤12.0 V |
| leg_mode | input | 2 | 0 default, 1 fixed 9 V, 2 fixed 12 V, 3 continuous |
| vout_code | input | 8 | Measured output voltage, 100 mV per LSB |
| cs_low | input | 1 | Load current below light-load level |
| dl_ovp | input | 1 | Data-line overvoltage comparator |
| cable_fault | input | 1 | Qualified cable fault |
| fb_pulldown | output | 1 | Feedback pull-down latch |
| cc_reduce | output | 1 | Request for reduced current limit |
| sr_disable | output | 1 | Block synchronous-rectifier gating |
| light_load | output | 1 | Light-load mode active |

## Verification
The bench sweeps the code across every band limit and both undervoltage enter and exit levels. A design using `>=` in place of `>`, or picking the wrong band, would latch one code early or late. Each debounce is driven with a pulse one tick short of its window, dropped, then driven short again. A counter that does not restart would add the two pulses and fire too early. The release boundary is probed at exactly code 20 and code 19, and both undervoltage variants run side by side. This catches a latch that leaks on the variant choice, and undervoltage that stays armed in continuous mode.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] vcode_t;

    typedef enum logic [1:0] {
        BAND_5V  = 2'd0,
        BAND_6V  = 2'd1,
        BAND_9V  = 2'd2,
        BAND_12V = 2'd3
    } band_e;

    typedef enum logic [1:0] {
        LEG_DEFAULT = 2'd0,
        LEG_9V      = 2'd1,
        LEG_12V     = 2'd2,
        LEG_CONT    = 2'd3
    } leg_e;

    typedef enum logic {
        UV_CUT_CC = 1'b0,
        UV_LATCH  = 1'b1
    } uv_react_e;

    typedef struct packed {
        logic   armed;
        vcode_t enter_below;
        vcode_t leave_above;
    } uv_thr_t;

    function automatic vcode_t ovp_limit(band_e b);
        case (b)
            BAND_5V:  return vcode_t'(60);
            BAND_6V:  return vcode_t'(84);
            BAND_9V:  return vcode_t'(108);
            default:  return vcode_t'(144);
        endcase
    endfunction

    function automatic uv_thr_t uv_limits(leg_e m);
        uv_thr_t t;
        t.armed       = 1'b0;
        t.enter_below = '0;
        t.leave_above = '0;
        case (m)
            LEG_9V: begin
                t.armed       = 1'b1;
                t.enter_below = vcode_t'(55);
                t.leave_above = vcode_t'(60);
            end
            LEG_12V: begin
                t.armed       = 1'b1;
                t.enter_below = vcode_t'(80);
                t.leave_above = vcode_t'(85);
            end
            default: ;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/prot_debounce.sv
module prot_debounce #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !cond) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = cond && (cnt == LIM);
endmodule

// File: rtl/out_prot_latch.sv
module out_prot_latch #(
    parameter prot_pkg::uv_react_e UV_REACT = prot_pkg::UV_CUT_CC,
    parameter int OVP_DEB_US     = 33,
    parameter int DL_DEB_US      = 3000,
    parameter int UV_DEB_US      = 60000,
    parameter int LL_EN_US       = 100,
    parameter int LL_DIS_US      = 12000,
    parameter int LATCH_OFF_CODE = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       us_tick,
    input  logic [1:0] band,
    input  logic [1:0] leg_mode,
    input  logic [7:0] vout_code,
    input  logic       cs_low,
    input  logic       dl_ovp,
    input  logic       cable_fault,
    output logic       fb_pulldown,
    output logic       cc_reduce,
    output logic       sr_disable,
    output logic       light_load
);
    import prot_pkg::*;

    localparam vcode_t REL_CODE = vcode_t'(LATCH_OFF_CODE);

    uv_thr_t uv_t;
    logic    ovp_raw, ovp_hit, dl_hit, uv_raw, uv_hit;
    logic    ll_en_hit, ll_dis_hit;
    logic    uv_act, uv_to_latch, release_now, latch_set;

    assign uv_t    = uv_limits(leg_e'(leg_mode));
    assign ovp_raw = vout_code > ovp_limit(band_e'(band));
    assign uv_raw  = uv_t.armed && (vout_code < uv_t.enter_below);

    prot_debounce #(.LIMIT(OVP_DEB_US)) u_ovp_deb (
        .clk(clk), .rst(rst), .tick(us_tick), .cond(ovp_raw), .hit(ovp_hit));
    prot_debounce #(.LIMIT(DL_DEB_US)) u_dl_deb (
        .clk(clk), .rst(rst), .tick(us_tick), .cond(dl_ovp), .hit(dl_hit));
    prot_debounce #(.LIMIT(UV_DEB_US)) u_uv_deb (
        .clk(clk), .rst(rst), .tick(us_tick), .cond(uv_raw), .hit(uv_hit));
    prot_debounce #(.LIMIT(LL_EN_US)) u_ll_en (
        .clk(clk), .rst(rst), .tick(us_tick), .cond(cs_low), .hit(ll_en_hit));
    prot_debounce #(.LIMIT(LL_DIS_US)) u_ll_dis (
        .clk(clk), .rst(rst), .tick(us_tick), .cond(!cs_low), .hit(ll_dis_hit));

    // Undervoltage state: debounced entry, immediate exit on recovery or disarm.
    always_ff @(posedge clk) begin
        if (rst || !uv_t.armed || (vout_code > uv_t.leave_above)) begin
            uv_act <= 1'b0;
        end else if (uv_hit) begin
            uv_act <= 1'b1;
        end
    end

    // Variant selection for the undervoltage reaction.
    generate
        if (UV_REACT == UV_CUT_CC) begin : g_uv_cut
            assign cc_reduce   = uv_act;
            assign uv_to_latch = 1'b0;
        end else begin : g_uv_latch
            assign cc_reduce   = 1'b0;
            assign uv_to_latch = uv_act;
        end
    endgenerate

    assign release_now = vout_code < REL_CODE;
    assign latch_set   = ovp_hit || dl_hit || cable_fault || uv_to_latch;

    always_ff @(posedge clk) begin
        if (rst || release_now) begin
            fb_pulldown <= 1'b0;
        end else if (latch_set) begin
            fb_pulldown <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            light_load <= 1'b0;
        end else if (!light_load && ll_en_hit) begin
            light_load <= 1'b1;
        end else if (light_load && ll_dis_hit) begin
            light_load <= 1'b0;
        end
    end

    assign sr_disable = uv_act || light_load;
endmodule

// File: rtl/out_prot_latch_chk.sv
module out_prot_latch_chk #(
    parameter int LATCH_OFF_CODE = 20
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] leg_mode,
    input logic [7:0] vout_code,
    input logic       cs_low,
    input logic       cable_fault,
    input logic       fb_pulldown,
    input logic       cc_reduce,
    input logic       sr_disable,
    input logic       light_load
);
    localparam logic [7:0] REL = 8'(LATCH_OFF_CODE);

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (fb_pulldown && vout_code >= REL) |=> fb_pulldown);

    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (vout_code < REL) |=> !fb_pulldown);

    a_r5_cable_sets: assert property (@(posedge clk) disable iff (rst)
        (cable_fault && vout_code >= REL) |=> fb_pulldown);

    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        !(leg_mode == 2'd1 || leg_mode == 2'd2) |=> !cc_reduce);

    a_r10_uv_blocks_sr: assert property (@(posedge clk) disable iff (rst)
        cc_reduce |-> sr_disable);

    a_r11_ll_enter_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(light_load) |-> $past(cs_low));

    a_r11_ll_leave_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(light_load) |-> $past(!cs_low));
endmodule

bind out_prot_latch out_prot_latch_chk #(.LATCH_OFF_CODE(LATCH_OFF_CODE)) u_chk (
    .clk(clk), .rst(rst), .leg_mode(leg_mode), .vout_code(vout_code),
    .cs_low(cs_low), .cable_fault(cable_fault), .fb_pulldown(fb_pulldown),
    .cc_reduce(cc_reduce), .sr_disable(sr_disable), .light_load(light_load));

// File: tb/out_prot_latch_tb_top.sv
module out_prot_latch_tb_top;
    localparam int OVP_T = 8;
    localparam int DL_T  = 6;
    localparam int UV_T  = 20;
    localparam int LLE_T = 10;
    localparam int LLD_T = 25;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] band = 2'd0;
    logic [1:0] leg_mode = 2'd0;
    logic [7:0] vout_code = 8'd50;
    logic       cs_low = 1'b0;
    logic       dl_ovp = 1'b0;
    logic       cable_fault = 1'b0;
    logic       fb_a, cc_a, sr_a, ll_a;
    logic       fb_b, cc_b, sr_b, ll_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) tick <= ~tick;

    out_prot_latch #(.UV_REACT(prot_pkg::UV_CUT_CC), .OVP_DEB_US(OVP_T),
        .DL_DEB_US(DL_T), .UV_DEB_US(UV_T), .LL_EN_US(LLE_T),
        .LL_DIS_US(LLD_T), .LATCH_OFF_CODE(20)) dut_i (
        .clk(clk), .rst(rst), .us_tick(tick), .band(band), .leg_mode(leg_mode),
        .vout_code(vout_code), .cs_low(cs_low), .dl_ovp(dl_ovp),
        .cable_fault(cable_fault), .fb_pulldown(fb_a), .cc_reduce(cc_a),
        .sr_disable(sr_a), .light_load(ll_a));

    out_prot_latch #(.UV_REACT(prot_pkg::UV_LATCH), .OVP_DEB_US(OVP_T),
        .DL_DEB_US(DL_T), .UV_DEB_US(UV_T), .LL_EN_US(LLE_T),
        .LL_DIS_US(LLD_T), .LATCH_OFF_CODE(20)) dut_l (
        .clk(clk), .rst(rst), .us_tick(tick), .band(band), .leg_mode(leg_mode),
        .vout_code(vout_code), .cs_low(cs_low), .dl_ovp(dl_ovp),
        .cable_fault(cable_fault), .fb_pulldown(fb_b), .cc_reduce(cc_b),
        .sr_disable(sr_b), .light_load(ll_b));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int band_limit(input int b);
        return (b == 0) ? 60 : (b == 1) ? 84 : (b == 2) ? 108 : 144;
    endfunction

    task automatic release_latch();
        leg_mode = 2'd0;
        vout_code = 8'd10;
        cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(4);
        check("R1 fb after reset", fb_a, 0);
        check("R1 cc after reset", cc_a, 0);
        rst = 1'b0;
        cyc(1);
        check("R1 sr after reset", sr_a, 0);
        check("R1 ll after reset", ll_a, 0);
        check("R1 fb latch variant", fb_b, 0);

        // R2: sweep each band limit
        for (int b = 0; b < 4; b++) begin
            for (int d = -2; d <= 2; d++) begin
                band = 2'(b);
                vout_code = 8'(band_limit(b) + d);
                cyc(2 * OVP_T + 8);
                check($sformatf("R2 band%0d d%0d", b, d), fb_a, (d > 0) ? 1 : 0);
                release_latch();
                check("R6 release after sweep", fb_a, 0);
            end
        end

        // R3: short overvoltage episodes do not accumulate
        band = 2'd0;
        vout_code = 8'd70; cyc(2 * (OVP_T - 1) - 1);
        vout_code = 8'd50; cyc(2);
        check("R3 short pulse 1", fb_a, 0);
        vout_code = 8'd70; cyc(2 * (OVP_T - 1) - 1);
        vout_code = 8'd50; cyc(2);
        check("R3 short pulse 2 restart", fb_a, 0);
        vout_code = 8'd70; cyc(2 * OVP_T + 8);
        check("R3 full window", fb_a, 1);
        vout_code = 8'd50; cyc(30);
        check("R6 sticky after cause gone", fb_a, 1);
        vout_code = 8'd20; cyc(3);
        check("R6 code 20 holds", fb_a, 1);
        vout_code = 8'd19; cyc(2);
        check("R6 code 19 releases", fb_a, 0);
        vout_code = 8'd50;

        // R4: data-line overvoltage
        dl_ovp = 1'b1; cyc(2 * (DL_T - 1) - 1);
        dl_ovp = 1'b0; cyc(2);
        check("R4 short data-line", fb_a, 0);
        dl_ovp = 1'b1; cyc(2 * (DL_T - 1) - 1);
        dl_ovp = 1'b0; cyc(2);
        check("R4 restart data-line", fb_a, 0);
        dl_ovp = 1'b1; cyc(2 * DL_T + 8);
        check("R4 data-line latches", fb_a, 1);
        dl_ovp = 1'b0;
        release_latch();
        vout_code = 8'd50;

        // R5: cable fault immediate
        cable_fault = 1'b1; cyc(1);
        check("R5 cable next edge", fb_a, 1);
        check("R5 cable latch variant", fb_b, 1);
        cable_fault = 1'b0;
        release_latch();
        check("R6 release cable", fb_a, 0);

        // R7..R10: undervoltage in 9 V mode
        band = 2'd2; vout_code = 8'd90; leg_mode = 2'd1; cyc(2);
        vout_code = 8'd55; cyc(2 * UV_T + 10);
        check("R7 code 55 not below", cc_a, 0);
        vout_code = 8'd54; cyc(2 * (UV_T - 1) - 1);
        check("R7 before window", cc_a, 0);
        cyc(13);
        check("R7 9V enters", cc_a, 1);
        check("R10 sr on uv", sr_a, 1);
        check("R9 cut variant no pulldown", fb_a, 0);
        check("R9 latch variant pulldown", fb_b, 1);
        check("R9 latch variant no cc", cc_b, 0);
        vout_code = 8'd60; cyc(3);
        check("R8 code 60 stays", cc_a, 1);
        vout_code = 8'd61; cyc(2);
        check("R8 code 61 exits", cc_a, 0);
        check("R10 sr clears", sr_a, 0);
        check("R6 latch variant sticky", fb_b, 1);
        release_latch();

        // R8: disarm by mode change; R7: continuous/default never arm
        band = 2'd2; vout_code = 8'd54; leg_mode = 2'd1; cyc(2 * UV_T + 10);
        check("R7 9V re-enter", cc_a, 1);
        leg_mode = 2'd3; cyc(2);
        check("R8 disarm clears", cc_a, 0);
        cyc(2 * UV_T + 10);
        check("R7 continuous unarmed", cc_a, 0);
        leg_mode = 2'd0; cyc(2 * UV_T + 10);
        check("R7 default unarmed", cc_a, 0);
        release_latch();

        // R7/R8: 12 V mode thresholds
        band = 2'd2; vout_code = 8'd90; leg_mode = 2'd2; cyc(2);
        vout_code = 8'd80; cyc(2 * UV_T + 10);
        check("R7 12V code 80 not below", cc_a, 0);
        vout_code = 8'd79; cyc(2 * UV_T + 10);
        check("R7 12V enters", cc_a, 1);
        vout_code = 8'd85; cyc(3);
        check("R8 12V code 85 stays", cc_a, 1);
        vout_code = 8'd86; cyc(2);
        check("R8 12V code 86 exits", cc_a, 0);
        release_latch();

        // R11: light-load mode
        band = 2'd0; vout_code = 8'd50;
        cs_low = 1'b1; cyc(2 * (LLE_T - 1) - 1);
        cs_low = 1'b0; cyc(2);
        check("R11 short low load", ll_a, 0);
        cs_low = 1'b1; cyc(2 * (LLE_T - 1) - 1);
        check("R11 restart low load", ll_a, 0);
        cyc(10);
        check("R11 enters", ll_a, 1);
        check("R10 sr on light load", sr_a, 1);
        cs_low = 1'b0; cyc(2 * (LLD_T - 1) - 1);
        check("R11 exit window pending", ll_a, 1);
        cs_low = 1'b1; cyc(2);
        cs_low = 1'b0; cyc(2 * (LLD_T - 1) - 1);
        check("R11 exit restart", ll_a, 1);
        cyc(15);
        check("R11 leaves", ll_a, 0);
        check("R10 sr off", sr_a, 0);
        check("R9 cc untouched by load", cc_a, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule